// File: doc/BRIEF.md
# Echo Ring Buffer Address Generator

This block drives the shared RAM port of a stereo echo delay line. A slot sequencer provides the cycle number of a 32-cycle sample loop. In a few fixed slots of each loop the block presents an address, a read or write strobe and a left/right channel select. Left and right samples are read early in the loop and written back near its end. Filter arithmetic and the RAM itself sit outside the block.

The buffer position is a running byte offset that advances by one 4-byte stereo frame per loop. It wraps to zero at the end of a buffer whose length comes from a delay register. The base address comes from a start-page register. Both register values take effect late, on purpose. The start page is captured near the end of a loop and used in the next loop's pointer computation. A new delay length is adopted only while the offset sits at zero. An active-high echo-disable flag can block each channel's write-back on its own, because the flag is sampled separately for each channel. Reads are never blocked.

Top module: `echo_addr_gen`

## Requirements
- R1: In cycle 22, memRd=1, memWr=0 and chanRight=0. memAddr equals (captured page × 256 + offset) mod 65536, and this value is kept as the loop's frame pointer.
- R2: In cycle 23, memRd=1, memWr=0, chanRight=1 and memAddr = (frame pointer + 2) mod 65536.
- R3: In cycle 29, memAddr = frame pointer and chanRight=0. memWr=1 only if echoDisable was 0 in cycle 28 of the same loop. memRd=0.
- R4: In cycle 30, memAddr = (frame pointer + 2) mod 65536 and chanRight=1. memWr=1 only if echoDisable was 0 in cycle 29. memRd=0. A set echoDisable never affects the reads of R1 and R2.
- R5: delayLen is sampled only in cycle 29, and only while the offset is zero. The buffer length becomes delayLen × 2048 bytes, or 4 bytes when delayLen is 0. At any other time delayLen has no effect.
- R6: The offset changes only in cycle 30. It becomes offset + 4, or 0 when offset + 4 is greater than or equal to the buffer length.
- R7: startPage is captured only in cycle 29 and is used by the next cycle-22 pointer computation. Its value in any other cycle has no effect.
- R8: In every cycle other than 22, 23, 29 and 30, memRd=0, memWr=0, chanRight=0 and memAddr=0.
- R9: Reset sets the offset, captured page and frame pointer to zero, the buffer length to 4 bytes, and both write permissions to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleNum | input | 5 | Current slot of the 32-cycle sample loop |
| startPage | input | 8 | Start-page register value (buffer base = page × 256) |
| delayLen | input | 4 | Delay register value (length = value × 2048 bytes) |
| echoDisable | input | 1 | Active-high flag that blocks echo write-back |
| memAddr | output | 16 | RAM byte address |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| chanRight | output | 1 | 1 when the access is for the right channel |

## Verification
The assertions check on every cycle that at most one access slot is active and that the offset stays 4-aligned and below the buffer length. They also check that the offset moves only by one step or a wrap, and that the length changes only from a zero offset. Further properties check that a right read sits 2 bytes above the preceding left read, and that every write follows a cycle with the disable flag low. Only the bench scenarios can show the delayed effects. These are: a start page or delay value written between sample points is ignored, a delay change waits for the next wrap, and the addresses wrap at the top of the 64 KiB space. The bench also shows per-channel write gating driven by disable pulses placed in cycle 28 or cycle 29.

// File: rtl/echo_addr_pkg.sv
package echo_addr_pkg;
  parameter int CYC_W     = 5;
  parameter int PAGE_W    = 8;
  parameter int DLY_W     = 4;
  parameter int LEN_SHIFT = 11;
  parameter int STEP      = 4;

  localparam int ADDR_W = PAGE_W + 8;
  localparam int LEN_W  = DLY_W + LEN_SHIFT;

  localparam int SLOT_RD_LEFT  = 22;
  localparam int SLOT_RD_RIGHT = 23;
  localparam int SLOT_EN_LEFT  = 28;
  localparam int SLOT_WR_LEFT  = 29;
  localparam int SLOT_WR_RIGHT = 30;

  typedef struct packed {
    logic rdLeft;
    logic rdRight;
    logic wrLeft;
    logic wrRight;
    logic sampEnL;
    logic sampEnR;
    logic latchCfg;
    logic advance;
  } echo_strobe_t;
endpackage

// File: rtl/echo_addr_ctrl.sv
module echo_addr_ctrl
  import echo_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CYC_W-1:0] cycleNum,
  output echo_strobe_t     stb
);
  function automatic logic isSlot(input logic [CYC_W-1:0] c, input int s);
    return c == CYC_W'(s);
  endfunction

  always_comb begin
    stb          = '0;
    stb.rdLeft   = isSlot(cycleNum, SLOT_RD_LEFT);
    stb.rdRight  = isSlot(cycleNum, SLOT_RD_RIGHT);
    stb.sampEnL  = isSlot(cycleNum, SLOT_EN_LEFT);
    stb.wrLeft   = isSlot(cycleNum, SLOT_WR_LEFT);
    stb.sampEnR  = isSlot(cycleNum, SLOT_WR_LEFT);
    stb.latchCfg = isSlot(cycleNum, SLOT_WR_LEFT);
    stb.wrRight  = isSlot(cycleNum, SLOT_WR_RIGHT);
    stb.advance  = isSlot(cycleNum, SLOT_WR_RIGHT);
  end

  AST_ONE_ACCESS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdLeft, stb.rdRight, stb.wrLeft, stb.wrRight})); // R8
endmodule

// File: rtl/echo_addr_dp.sv
module echo_addr_dp
  import echo_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  echo_strobe_t      stb,
  input  logic [PAGE_W-1:0] startPage,
  input  logic [DLY_W-1:0]  delayLen,
  input  logic              echoDisable,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic              chanRight
);
  logic [LEN_W-1:0]  offset;
  logic [LEN_W-1:0]  bufLen;
  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] pointer;
  logic              enLeft;
  logic              enRight;

  logic [ADDR_W-1:0] ptrCalc;
  logic [ADDR_W-1:0] ptrRight;
  logic [LEN_W:0]    offStep;
  logic              wrapHit;
  logic [LEN_W-1:0]  lenFromDelay;

  always_comb begin
    ptrCalc      = {page, 8'h00} + ADDR_W'(offset);
    ptrRight     = pointer + ADDR_W'(2);
    offStep      = {1'b0, offset} + (LEN_W + 1)'(STEP);
    wrapHit      = offStep >= {1'b0, bufLen};
    lenFromDelay = (delayLen == '0) ? LEN_W'(STEP)
                                    : {delayLen, {LEN_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offset  <= '0;
      bufLen  <= LEN_W'(STEP);
      page    <= '0;
      pointer <= '0;
      enLeft  <= 1'b0;
      enRight <= 1'b0;
    end else begin
      if (stb.rdLeft)  pointer <= ptrCalc;
      if (stb.sampEnL) enLeft  <= !echoDisable;
      if (stb.sampEnR) enRight <= !echoDisable;
      if (stb.latchCfg) begin
        page <= startPage;
        if (offset == '0) bufLen <= lenFromDelay;
      end
      if (stb.advance) offset <= wrapHit ? '0 : offStep[LEN_W-1:0];
    end
  end

  always_comb begin
    memAddr   = '0;
    memRd     = 1'b0;
    memWr     = 1'b0;
    chanRight = 1'b0;
    if (stb.rdLeft) begin
      memAddr = ptrCalc;
      memRd   = 1'b1;
    end else if (stb.rdRight) begin
      memAddr   = ptrRight;
      memRd     = 1'b1;
      chanRight = 1'b1;
    end else if (stb.wrLeft) begin
      memAddr = pointer;
      memWr   = enLeft;
    end else if (stb.wrRight) begin
      memAddr   = ptrRight;
      memWr     = enRight;
      chanRight = 1'b1;
    end
  end

  AST_OFFSET_BELOW_LEN: assert property (@(posedge clk) disable iff (!rstN)
    offset < bufLen); // R6
  AST_OFFSET_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    offset[1:0] == 2'b00); // R6
  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (offset == '0) || (offset == $past(offset) + LEN_W'(STEP))); // R6
  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(offset)); // R6
  AST_LEN_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (bufLen != $past(bufLen)) |-> ($past(offset) == '0)); // R5
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchCfg |=> $stable(page)); // R7
endmodule

// File: rtl/echo_addr_gen.sv
module echo_addr_gen
  import echo_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CYC_W-1:0]  cycleNum,
  input  logic [PAGE_W-1:0] startPage,
  input  logic [DLY_W-1:0]  delayLen,
  input  logic              echoDisable,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic              chanRight
);
  echo_strobe_t stb;

  echo_addr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cycleNum (cycleNum),
    .stb      (stb)
  );

  echo_addr_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .startPage   (startPage),
    .delayLen    (delayLen),
    .echoDisable (echoDisable),
    .memAddr     (memAddr),
    .memRd       (memRd),
    .memWr       (memWr),
    .chanRight   (chanRight)
  );

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R8
  AST_RIGHT_ABOVE_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && chanRight && $past(memRd) && !$past(chanRight))
      |-> (memAddr == $past(memAddr) + ADDR_W'(2))); // R2
  AST_LEFT_WR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !chanRight) |-> !$past(echoDisable)); // R3
  AST_RIGHT_WR_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && chanRight) |-> !$past(echoDisable)); // R4
endmodule

// File: tb/echo_addr_gen_tb_top.sv
module echo_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  cycleNum = '0;
  logic [7:0]  startPage = '0;
  logic [3:0]  delayLen = '0;
  logic        echoDisable = 1'b0;
  logic [15:0] memAddr;
  logic        memRd, memWr, chanRight;

  int testsRun = 0;
  int testsFailed = 0;

  // behavioural reference state
  int mOff = 0, mLen = 4, mPage = 0, mPtr = 0;
  bit mEnL = 0, mEnR = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  echo_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .cycleNum(cycleNum), .startPage(startPage),
    .delayLen(delayLen), .echoDisable(echoDisable), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .chanRight(chanRight)
  );

  task automatic step(input int cyc, input logic [7:0] pg, input logic [3:0] dl,
                      input logic dis, input string scen);
    int  eAddr;
    bit  eRd, eWr, eRight;
    string tag;
    @(negedge clk);
    cycleNum = cyc[4:0]; startPage = pg; delayLen = dl; echoDisable = dis;
    #1;
    eAddr = 0; eRd = 0; eWr = 0; eRight = 0; tag = "R8";
    case (cyc)
      22: begin eAddr = (mPage * 256 + mOff) % 65536; eRd = 1; tag = "R1"; end
      23: begin eAddr = (mPtr + 2) % 65536; eRd = 1; eRight = 1; tag = "R2"; end
      29: begin eAddr = mPtr; eWr = mEnL; tag = "R3"; end
      30: begin eAddr = (mPtr + 2) % 65536; eWr = mEnR; eRight = 1; tag = "R4"; end
      default: ;
    endcase
    testsRun++;
    if (memAddr !== eAddr[15:0] || memRd !== eRd || memWr !== eWr || chanRight !== eRight) begin
      testsFailed++;
      $display("FAIL %s [%s] cycle %0d: addr/rd/wr/right actual %h/%b/%b/%b expected %h/%b/%b/%b",
               tag, scen, cyc, memAddr, memRd, memWr, chanRight, eAddr[15:0], eRd, eWr, eRight);
    end
    // model update for the coming clock edge
    case (cyc)
      22: mPtr = eAddr;
      28: mEnL = !dis;
      29: begin
        mEnR  = !dis;
        mPage = pg;
        if (mOff == 0) mLen = (dl == 0) ? 4 : dl * 2048;
      end
      30: begin
        mOff = mOff + 4;
        if (mOff >= mLen) mOff = 0;
      end
      default: ;
    endcase
  endtask

  // One loop: page/delay only valid in cycle 29 (R7, R5), other cycles carry junk.
  // The disable flag takes d28 in cycle 28, d29 in cycle 29 and toggles elsewhere.
  task automatic runLoop(input logic [7:0] pg, input logic [3:0] dl,
                         input logic d28, input logic d29, input string scen);
    for (int c = 0; c < 32; c++) begin
      logic [7:0] p;
      logic [3:0] d;
      logic       x;
      p = (c == 29) ? pg : pg ^ 8'h5A;
      d = (c == 29) ? dl : ~dl;
      x = (c == 28) ? d28 : (c == 29) ? d29 : logic'(c % 2);
      step(c, p, d, x, scen);
    end
  endtask

  initial begin
    // R9: reset state, read address with reset page and offset is zero
    cycleNum = 5'd22;
    #(CLK_PERIOD * 3 + 2);
    testsRun++;
    if (memAddr !== 16'h0000 || memRd !== 1'b1 || memWr !== 1'b0) begin
      testsFailed++;
      $display("FAIL R9 reset read: actual %h/%b/%b expected 0000/1/0", memAddr, memRd, memWr);
    end
    cycleNum = 5'd0;
    @(negedge clk);
    rstN = 1'b1;

    // R9, R1..R4: zero delay keeps a 4-byte buffer, offset pinned to 0 (R5, R6)
    runLoop(8'h12, 4'd0, 1'b0, 1'b0, "R9 first loop");
    for (int i = 0; i < 3; i++) runLoop(8'h12, 4'd0, 1'b0, 1'b0, "R5 zero delay");

    // R3/R4: per-channel write gating; reads continue (R4)
    runLoop(8'h12, 4'd0, 1'b1, 1'b0, "R3 left blocked");
    runLoop(8'h12, 4'd0, 1'b0, 1'b1, "R4 right blocked");
    runLoop(8'h12, 4'd0, 1'b1, 1'b1, "R4 both blocked");

    // R6/R7: 2048-byte buffer, page 0xFF makes addresses wrap past 64 KiB (R2)
    for (int i = 0; i < 300; i++)
      runLoop((i < 200) ? 8'hFF : 8'h30, 4'd1, (i % 4) == 1, (i % 4) == 2, "R6 R7 delay1");

    // R5: delay 2 written mid-buffer, adopted only after the wrap
    for (int i = 0; i < 300; i++)
      runLoop((i % 50 < 25) ? 8'hFE : 8'h81, 4'd2, (i % 3) == 0, (i % 5) == 0, "R5 late delay");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule